// File: doc/BRIEF.md
# Polled Keyset Concentrating Multiplexor

This block lets 32 keyboard terminals share one outgoing serial line. Each terminal offers an 8-bit character together with a ready flag and holds both until it is acknowledged. A scanner visits the channels one per clock. When it meets a channel that has a character waiting, it stops there. It then builds a 14-bit word from the character, the channel's own 5-bit number and an odd parity bit, pulses that channel's acknowledge, and sends the word as an asynchronous frame at a fixed bit rate. When the stop bit ends, the scan moves on from the next channel.

Because the scanner only stops on channels that have data, the line's capacity is split among whichever terminals are typing. One busy terminal gets the whole line. With every terminal busy, each one gets an equal share. The bit period comes from a clock-enable divider whose ratio is set by the system clock frequency and the bit rate, both given as parameters.

Top module: `keyset_concentrator`

## Requirements
- R1: After reset the serial line is high and no acknowledge is asserted.
- R2: A frame is a low start bit, then the 14 word bits with bit 0 first, then a high stop bit. Each bit lasts CLK_HZ/BIT_RATE clocks.
- R3: In the word, bit 0 is parity, bits 1 to 8 carry the character (bit 1 holds the character's LSB), and bits 9 to 13 carry the channel number (bit 9 holds its LSB).
- R4: Parity is odd, so the 14-bit word always contains an odd number of ones.
- R5: Only one frame is in flight at a time. No other channel is acknowledged or loaded until the current frame's stop bit has finished.
- R6: Each frame is acknowledged exactly once. The acknowledge is a one-clock, one-hot pulse on the served channel, asserted in the clock that follows the load (the first clock of the start bit).
- R7: After a frame, the next channel served is the first ready channel after the one just served, wrapping from channel 31 to channel 0. A channel that asks again at once cannot pass channels waiting behind it.
- R8: With no channel ready, the line stays high and no acknowledge is given.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| chReady | input | 32 | Per-channel character-waiting flag, held until acknowledged |
| chData | input | 256 | Per-channel characters, channel n in bits [8n+7:8n] |
| chAck | output | 32 | One-clock acknowledge pulse to the served channel |
| serOut | output | 1 | Serial line output, high when idle |

## Verification
The frame format is tested with characters of all zeros, all ones and a mixed pattern. These are sent on the lowest channel, the highest channel and a middle channel, so that a swapped field, a reversed bit order or an even-parity generator each decode to a value that can be told apart from the right one. The scan order is tested by raising several requests while another channel's frame is on the line. It is also tested with a request that wraps past channel 31, and with a channel that asks again immediately. This separates a true rotating scan from a fixed-priority search or a scan that restarts from channel 0. Counting acknowledges in the middle of each frame shows whether the scanner really stalls, and a quiet stretch with no requests shows whether the line idles cleanly.

// File: rtl/kc_pkg.sv
package kc_pkg;

  // channel address width; channel count derives from it
  parameter int KC_CH_W = 5;
  localparam int KC_NUM_CH = 1 << KC_CH_W;

  typedef enum logic {
    KC_SCAN = 1'b0,
    KC_SEND = 1'b1
  } kcState_e;

  // strobes from the scan control to the frame datapath
  typedef struct packed {
    logic               load;
    logic [KC_CH_W-1:0] sel;
  } kcCtrl_t;

endpackage

// File: rtl/kc_bit_tick.sv
module kc_bit_tick #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic en,
  input  logic clr,
  output logic tick
);

  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] divCnt;

  assign tick = en && (divCnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rstN || clr || tick) begin
      divCnt <= '0;
    end else if (en) begin
      divCnt <= divCnt + 1'b1;
    end
  end

endmodule

// File: rtl/kc_frame_dp.sv
module kc_frame_dp
  import kc_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int DIV    = 10
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  kcCtrl_t                       ctrl,
  input  logic [KC_NUM_CH*CHAR_W-1:0]   chData,
  output logic                          serOut,
  output logic                          busy,
  output logic                          frameDone
);

  localparam int WORD_W     = 1 + CHAR_W + KC_CH_W;
  localparam int FRAME_BITS = WORD_W + 2;
  localparam int BC_W       = $clog2(FRAME_BITS + 1);

  logic [CHAR_W-1:0]         chosenChar;
  logic [CHAR_W+KC_CH_W-1:0] payload;
  logic                      parityBit;
  logic [WORD_W-1:0]         wordNext;
  logic [WORD_W:0]           shiftReg;
  logic [BC_W-1:0]           bitsLeft;
  logic                      lineReg;
  logic                      bitTick;

  assign chosenChar = chData[ctrl.sel*CHAR_W +: CHAR_W];
  assign payload    = {ctrl.sel, chosenChar};
  assign parityBit  = ~^payload;
  assign wordNext   = {payload, parityBit};

  kc_bit_tick #(.DIV(DIV)) i_tick (
    .clk (clk),
    .rstN(rstN),
    .en  (busy),
    .clr (ctrl.load),
    .tick(bitTick)
  );

  assign frameDone = bitTick && (bitsLeft == BC_W'(1));
  assign serOut    = lineReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '1;
      bitsLeft <= '0;
      lineReg  <= 1'b1;
      busy     <= 1'b0;
    end else if (ctrl.load) begin
      shiftReg <= {1'b1, wordNext};
      bitsLeft <= BC_W'(FRAME_BITS);
      lineReg  <= 1'b0;
      busy     <= 1'b1;
    end else if (bitTick) begin
      lineReg  <= shiftReg[0];
      shiftReg <= {1'b1, shiftReg[WORD_W:1]};
      bitsLeft <= bitsLeft - 1'b1;
      if (bitsLeft == BC_W'(1)) busy <= 1'b0;
    end
  end

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> serOut); // R8
  AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |=> !serOut); // R2
  AST_WORD_ODD_PARITY: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |=> ($countones(shiftReg[WORD_W-1:0]) % 2 == 1)); // R4
  AST_FRAME_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |=> busy); // R5

endmodule

// File: rtl/kc_scan_ctrl.sv
module kc_scan_ctrl
  import kc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [KC_NUM_CH-1:0] chReady,
  input  logic                 frameDone,
  input  logic                 busy,
  output kcCtrl_t              ctrl,
  output logic [KC_NUM_CH-1:0] chAck
);

  kcState_e           state;
  logic [KC_CH_W-1:0] scanPtr;

  assign ctrl.load = (state == KC_SCAN) && chReady[scanPtr];
  assign ctrl.sel  = scanPtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= KC_SCAN;
      scanPtr <= '0;
      chAck   <= '0;
    end else begin
      chAck <= '0;
      case (state)
        KC_SCAN: begin
          if (chReady[scanPtr]) begin
            state          <= KC_SEND;
            chAck[scanPtr] <= 1'b1;
          end else begin
            scanPtr <= scanPtr + 1'b1;
          end
        end
        default: begin
          if (frameDone) begin
            state   <= KC_SCAN;
            scanPtr <= scanPtr + 1'b1;
          end
        end
      endcase
    end
  end

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chAck)); // R6
  AST_ACK_ON_SERVED: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |=> chAck[$past(scanPtr)]); // R6
  AST_NO_LOAD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !ctrl.load); // R5
  AST_RESUME_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> (scanPtr == KC_CH_W'($past(scanPtr) + 1'b1))); // R7

endmodule

// File: rtl/keyset_concentrator.sv
module keyset_concentrator
  import kc_pkg::*;
#(
  parameter int CLK_HZ   = 250_000_000,
  parameter int BIT_RATE = 1200,
  parameter int CHAR_W   = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [KC_NUM_CH-1:0]        chReady,
  input  logic [KC_NUM_CH*CHAR_W-1:0] chData,
  output logic [KC_NUM_CH-1:0]        chAck,
  output logic                        serOut
);

  localparam int DIV = CLK_HZ / BIT_RATE;

  kcCtrl_t ctrl;
  logic    busy;
  logic    frameDone;

  kc_scan_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .chReady  (chReady),
    .frameDone(frameDone),
    .busy     (busy),
    .ctrl     (ctrl),
    .chAck    (chAck)
  );

  kc_frame_dp #(.CHAR_W(CHAR_W), .DIV(DIV)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .chData   (chData),
    .serOut   (serOut),
    .busy     (busy),
    .frameDone(frameDone)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rstN |=> (serOut && chAck == '0)); // R1

endmodule

// File: tb/test_keyset_concentrator.sv
`timescale 1ns/1ps
module test_keyset_concentrator;

  localparam int NCH  = 32;
  localparam int CW   = 8;
  localparam int DIV  = 10;
  localparam int WW   = 14;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NCH-1:0]  chReady;
  logic [NCH*CW-1:0] chData;
  logic [NCH-1:0]  chAck;
  logic            serOut;

  int              reqCnt [NCH];
  int              ackCnt [NCH];
  logic [CW-1:0]   dataArr [NCH];

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 0;
  int  lastServed = 0;

  always #2 clk = ~clk;

  keyset_concentrator #(.CLK_HZ(12000), .BIT_RATE(1200), .CHAR_W(CW)) i_keyset_concentrator (
    .clk(clk), .rstN(rstN), .chReady(chReady), .chData(chData),
    .chAck(chAck), .serOut(serOut)
  );

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      chReady[i] = (reqCnt[i] != ackCnt[i]);
      chData[i*CW +: CW] = dataArr[i];
    end
  end

  always @(negedge clk) begin
    for (int i = 0; i < NCH; i++) if (chAck[i]) ackCnt[i] <= ackCnt[i] + 1;
  end

  function automatic int totalAcks();
    int s = 0;
    for (int i = 0; i < NCH; i++) s += ackCnt[i];
    return s;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic request(input int ch, input logic [CW-1:0] d);
    dataArr[ch] = d;
    reqCnt[ch]  = reqCnt[ch] + 1;
  endtask

  // waits for a start bit and samples each bit in its middle
  task automatic captureFrame(output logic [WW-1:0] w);
    int guard = 0;
    w = '0;
    @(negedge clk);
    while (serOut === 1'b1 && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    check(guard < 3000, "R2 frame start seen", guard, 0);
    repeat (DIV/2) @(negedge clk);
    check(serOut === 1'b0, "R2 start bit", serOut, 0);
    for (int b = 0; b < WW; b++) begin
      repeat (DIV) @(negedge clk);
      w[b] = serOut;
    end
    repeat (DIV) @(negedge clk);
    check(serOut === 1'b1, "R2 stop bit", serOut, 1);
  endtask

  task automatic expectFrame(input int expCh, input int acksBefore);
    logic [WW-1:0] w;
    captureFrame(w);
    check(w[13:9] == expCh[4:0], "R7 served channel", w[13:9], expCh);
    check(w[8:1] == dataArr[expCh], "R3 character field", w[8:1], dataArr[expCh]);
    check(($countones(w) % 2) == 1, "R4 odd parity", w, 0);
    check(totalAcks() == acksBefore + 1, "R6 one ack per frame", totalAcks(), acksBefore + 1);
    check(reqCnt[expCh] == ackCnt[expCh], "R6 ack on served channel", ackCnt[expCh], reqCnt[expCh]);
    lastServed = expCh;
  endtask

  task automatic testReset();
    check(serOut === 1'b1, "R1 line high after reset", serOut, 1);
    check(chAck === '0, "R1 no ack after reset", chAck, 0);
  endtask

  task automatic testSingle(input int ch, input logic [CW-1:0] d);
    int a0;
    @(negedge clk);
    a0 = totalAcks();
    request(ch, d);
    expectFrame(ch, a0);
  endtask

  task automatic testIdle();
    int a0 = totalAcks();
    bit allHigh = 1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (serOut !== 1'b1) allHigh = 0;
    end
    check(allHigh, "R8 line idles high", allHigh, 1);
    check(totalAcks() == a0, "R8 no ack when idle", totalAcks(), a0);
  endtask

  // first frame on 'first'; the other requests are raised while it is on the line
  task automatic testOrder(input int first, input int later[], input int expOrder[]);
    logic [WW-1:0] w;
    int a0;
    @(negedge clk);
    a0 = totalAcks();
    request(first, 8'h5A ^ first[7:0]);
    // catch the start and land in the middle of the start bit
    begin
      int guard = 0;
      @(negedge clk);
      while (serOut === 1'b1 && guard < 3000) begin @(negedge clk); guard++; end
      repeat (DIV/2) @(negedge clk);
    end
    foreach (later[k]) begin
      if (later[k] == first) begin
        request(first, 8'hC3);
      end else begin
        request(later[k], 8'h11 * (k + 1));
      end
    end
    repeat (DIV*15) @(negedge clk);
    check(totalAcks() == a0 + 1, "R5 no ack during frame", totalAcks(), a0 + 1);
    lastServed = first;
    foreach (expOrder[k]) expectFrame(expOrder[k], a0 + 1 + k);
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) begin
      reqCnt[i] = 0;
      dataArr[i] = '0;
    end
    for (int i = 0; i < NCH; i++) ackCnt[i] = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testIdle();
    testSingle(5, 8'hA5);   // R3 mixed pattern, middle channel
    testSingle(0, 8'h00);   // R4 all-zero payload gives parity 1
    testSingle(31, 8'hFF);  // R3 top channel, all ones
    testSingle(18, 8'h01);  // R3 character LSB lands in bit 1
    testOrder(10, '{3, 11, 25}, '{11, 25, 3});     // R7 rotating order
    testOrder(31, '{30, 0}, '{0, 30});             // R7 wrap past 31
    testOrder(2, '{9, 2}, '{9, 2});                // R7 re-request cannot starve
    testIdle();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule